// File: doc/BRIEF.md
# Asynchronous Serial Character Receiver

This block takes one asynchronous NRZ line and turns the characters on it into parallel words. An internal tick generator divides the clock by `baudDiv + 1`, and eight ticks make one bit period. The control side looks for a falling edge and confirms the start bit at mid-bit. For each bit that follows it takes a three-sample majority vote near the bit centre. Each frame carries one to eight data bits sent LSB first, then an optional address bit, an optional parity bit, and one or two stop bits.

A finished character moves into a holding register and raises a ready flag. Separate sticky flags report parity, framing, overrun and break conditions, and a summary flag combines them. For multiprocessor links the receiver offers two wake-up filters. The address-bit filter reads an extra bit after the data. The idle-line filter treats a long quiet line as the marker of an address character. While the sleep input is high, either filter drops characters that are not addresses.

Top module: `async_rx`

## Requirements
- R1: One bit period lasts 8*(baudDiv+1) clocks. A falling edge is accepted as a start bit only if the line is still low at the middle oversample of that bit, so a low pulse shorter than half a bit loads nothing.
- R2: The data length is dataLen+1 bits (dataLen 0..7 gives 1..8 bits), received LSB first. rxData holds the data right-aligned with its upper bits zero, and rxReady goes to 1 when the character is loaded.
- R3: With parityEn=1 a parity bit follows the data bits and the address bit. It covers both, and parityOdd=0 selects even parity over data, address and parity bit together. A mismatch sets errParity.
- R4: A first stop bit that samples low sets errFrame. With twoStop=1 a second stop bit is expected, and its value is not checked.
- R5: If a character completes while rxReady is still 1, errOverrun is set and the new character replaces the old one in rxData.
- R6: After a low first stop bit, if the line stays low for 80 more oversample ticks (ten bit periods), errBreak is set.
- R7: errAny is the OR of the four error flags. A one-cycle rdStrobe clears rxReady and all four error flags.
- R8: rxIrq is high when rxIntEn=1 and any of rxReady, errParity, errFrame or errOverrun is set. A set errBreak drives rxIrq high whatever rxIntEn is.
- R9: With mpMode=2 (address bit), one extra bit after the data is returned on rxAddr. While sleepEn=1, a character whose address bit is 0 is dropped, and neither the data nor any flag changes.
- R10: With mpMode=1 (idle line), a character preceded by at least 80 idle-high ticks gets rxAddr=1 and any other character gets rxAddr=0. While sleepEn=1, characters with rxAddr=0 are dropped. mpMode values 0 and 3 apply no filter.
- R11: While rxEn=0 the line is ignored: no character is loaded and no flag changes.
- R12: A bit's value is the majority of oversamples 3, 4 and 5 of that bit, so a glitch of one clock inside a bit does not change the received data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rxEn | input | 1 | Receiver enable |
| rxLine | input | 1 | Serial input line, idle high |
| baudDiv | input | 16 | Oversample tick divisor; a tick comes every baudDiv+1 clocks |
| dataLen | input | 3 | Data bits minus one |
| parityEn | input | 1 | Parity bit present |
| parityOdd | input | 1 | 1 = odd parity, 0 = even parity |
| twoStop | input | 1 | Two stop bits |
| mpMode | input | 2 | 0 none, 1 idle line, 2 address bit, 3 none |
| sleepEn | input | 1 | Drop non-address characters in a wake-up mode |
| rxIntEn | input | 1 | Gate for the ready, parity, framing and overrun interrupts |
| rdStrobe | input | 1 | Buffer read; clears ready and error flags |
| rxData | output | 8 | Received character, right-aligned |
| rxAddr | output | 1 | Address indication of the buffered character |
| rxReady | output | 1 | Buffer holds an unread character |
| errParity | output | 1 | Parity error |
| errFrame | output | 1 | Framing error |
| errOverrun | output | 1 | Overrun error |
| errBreak | output | 1 | Break detected |
| errAny | output | 1 | OR of the four error flags |
| rxIrq | output | 1 | Receive interrupt request |

## Verification
Three corner cases get direct tests. A start pulse shorter than half a bit must be rejected, or the receiver would assemble a character of all ones. A one-clock glitch inside a data bit must not change the data, since a single-sample decoder would flip that bit. The parity bit must cover the address bit, or a valid address frame would raise errParity. The bench also separates a framing error from a break by how long the line stays low, and a design that set the break flag on every low stop bit would fail. In the wake-up modes the bench checks dropped characters at the ports: a broken filter shows up as a set rxReady or a wrong rxAddr.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;
  localparam int OVS         = 8;
  localparam int PH_W        = $clog2(OVS);
  localparam int SMP_MID     = OVS / 2;
  localparam int SMP_LO      = SMP_MID - 1;
  localparam int SMP_HI      = SMP_MID + 1;
  localparam int PH_LAST     = OVS - 1;
  localparam int BREAK_BITS  = 10;
  localparam int IDLE_BITS   = 10;
  localparam int BREAK_TICKS = BREAK_BITS * OVS;
  localparam int IDLE_TICKS  = IDLE_BITS * OVS;
  localparam int CNT_W       = $clog2(BREAK_TICKS + IDLE_TICKS + 1);

  localparam logic [1:0] MP_NONE = 2'd0;
  localparam logic [1:0] MP_IDLE = 2'd1;
  localparam logic [1:0] MP_ADDR = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_ADDR, ST_PAR, ST_STOP1, ST_STOP2, ST_BRK
  } rxState_t;

  typedef struct packed {
    logic frameStart;
    logic idleAddr;
    logic shiftData;
    logic capAddr;
    logic capPar;
    logic bitVal;
    logic load;
    logic frameErr;
    logic setBreak;
  } rxStrb_t;
endpackage

// File: rtl/async_rx_ctrl.sv
module async_rx_ctrl
  import async_rx_pkg::*;
#(
  parameter int LEN_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxEn,
  input  logic             tick,
  input  logic             lineS,
  input  logic [LEN_W-1:0] dataLen,
  input  logic             parityEn,
  input  logic             twoStop,
  input  logic [1:0]       mpMode,
  output rxStrb_t          strb
);
  rxState_t          state;
  logic [PH_W-1:0]   ph;
  logic [LEN_W-1:0]  bitCnt;
  logic              smpA, smpB;
  logic [CNT_W-1:0]  idleCnt, brkCnt;
  logic              midVote, decide;
  rxState_t          afterData, afterAddr;

  assign midVote   = (smpA & smpB) | (smpA & lineS) | (smpB & lineS);
  assign decide    = tick && (ph == PH_W'(SMP_HI));
  assign afterAddr = parityEn ? ST_PAR : ST_STOP1;
  assign afterData = (mpMode == MP_ADDR) ? ST_ADDR : afterAddr;

  always_comb begin
    strb            = '0;
    strb.frameStart = rxEn && tick && (state == ST_IDLE) && !lineS;
    strb.idleAddr   = (idleCnt == CNT_W'(IDLE_TICKS));
    strb.bitVal     = midVote;
    strb.frameErr   = !midVote;
    strb.shiftData  = decide && (state == ST_DATA);
    strb.capAddr    = decide && (state == ST_ADDR);
    strb.capPar     = decide && (state == ST_PAR);
    strb.load       = decide && (state == ST_STOP1);
    strb.setBreak   = tick && (state == ST_BRK) && !lineS &&
                      (brkCnt == CNT_W'(BREAK_TICKS - 1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      ph      <= '0;
      bitCnt  <= '0;
      smpA    <= 1'b1;
      smpB    <= 1'b1;
      idleCnt <= '0;
      brkCnt  <= '0;
    end else if (!rxEn) begin
      state   <= ST_IDLE;
      ph      <= '0;
      idleCnt <= '0;
    end else if (tick) begin
      case (state)
        ST_IDLE: begin
          if (!lineS) begin
            state   <= ST_START;
            ph      <= PH_W'(1);
            idleCnt <= '0;
          end else if (idleCnt != CNT_W'(IDLE_TICKS)) begin
            idleCnt <= idleCnt + 1'b1;
          end
        end
        ST_BRK: begin
          if (lineS) state <= ST_IDLE;
          else if (brkCnt != CNT_W'(BREAK_TICKS)) brkCnt <= brkCnt + 1'b1;
        end
        default: begin
          ph <= ph + 1'b1;
          if (ph == PH_W'(SMP_LO))  smpA <= lineS;
          if (ph == PH_W'(SMP_MID)) smpB <= lineS;
          if (state == ST_START && ph == PH_W'(SMP_MID) && lineS) begin
            state <= ST_IDLE;                      // false start
          end else if (state == ST_STOP1 && ph == PH_W'(SMP_HI)) begin
            if (!midVote) begin
              state  <= ST_BRK;
              brkCnt <= '0;
            end else if (!twoStop) begin
              state <= ST_IDLE;
            end
          end else if (state == ST_STOP2 && ph == PH_W'(SMP_HI)) begin
            state <= ST_IDLE;
          end else if (ph == PH_W'(PH_LAST)) begin
            case (state)
              ST_START: begin state <= ST_DATA; bitCnt <= '0; end
              ST_DATA:  if (bitCnt == dataLen) state <= afterData;
                        else bitCnt <= bitCnt + 1'b1;
              ST_ADDR:  state <= afterAddr;
              ST_PAR:   state <= ST_STOP1;
              ST_STOP1: state <= ST_STOP2;
              default:  ;
            endcase
          end
        end
      endcase
    end
  end

  // R2: at most one frame action per cycle
  assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.frameStart, strb.shiftData, strb.capAddr, strb.capPar, strb.load, strb.setBreak}));

  // R11: a disabled receiver takes no frame action
  assert_disabled_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!rxEn && !$past(rxEn)) |-> !(strb.load || strb.shiftData || strb.setBreak));
endmodule

// File: rtl/async_rx_dp.sv
module async_rx_dp
  import async_rx_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int DATA_W = 8,
  parameter int LEN_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxLine,
  input  logic [DIV_W-1:0]  baudDiv,
  input  logic [LEN_W-1:0]  dataLen,
  input  logic              parityOdd,
  input  logic [1:0]        mpMode,
  input  logic              sleepEn,
  input  logic              rdStrobe,
  input  logic              rxIntEn,
  input  rxStrb_t           strb,
  output logic              tick,
  output logic              lineS,
  output logic [DATA_W-1:0] rxData,
  output logic              rxAddr,
  output logic              rxReady,
  output logic              errParity,
  output logic              errFrame,
  output logic              errOverrun,
  output logic              errBreak,
  output logic              errAny,
  output logic              rxIrq
);
  logic              lineMeta;
  logic [DIV_W-1:0]  divCnt;
  logic [DATA_W-1:0] shReg, aligned;
  logic              parAcc, parBad, addrCur, mpActive, keepNow;

  assign tick     = (divCnt == baudDiv);
  assign aligned  = shReg >> (LEN_W'(DATA_W - 1) - dataLen);
  assign mpActive = (mpMode == MP_IDLE) || (mpMode == MP_ADDR);
  assign keepNow  = !(sleepEn && mpActive && !addrCur);
  assign errAny   = errParity | errFrame | errOverrun | errBreak;
  assign rxIrq    = (rxIntEn & (rxReady | errParity | errFrame | errOverrun)) | errBreak;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineMeta <= 1'b1;
      lineS    <= 1'b1;
      divCnt   <= '0;
    end else begin
      lineMeta <= rxLine;
      lineS    <= lineMeta;
      divCnt   <= tick ? '0 : divCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg   <= '0;
      parAcc  <= 1'b0;
      parBad  <= 1'b0;
      addrCur <= 1'b0;
    end else if (strb.frameStart) begin
      shReg   <= '0;
      parAcc  <= 1'b0;
      parBad  <= 1'b0;
      addrCur <= (mpMode == MP_IDLE) && strb.idleAddr;
    end else begin
      if (strb.shiftData) shReg <= {strb.bitVal, shReg[DATA_W-1:1]};
      if (strb.shiftData || strb.capAddr) parAcc <= parAcc ^ strb.bitVal;
      if (strb.capAddr) addrCur <= strb.bitVal;
      if (strb.capPar) parBad <= parAcc ^ strb.bitVal ^ parityOdd;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData     <= '0;
      rxAddr     <= 1'b0;
      rxReady    <= 1'b0;
      errParity  <= 1'b0;
      errFrame   <= 1'b0;
      errOverrun <= 1'b0;
      errBreak   <= 1'b0;
    end else begin
      if (strb.load && keepNow) begin
        rxData     <= aligned;
        rxAddr     <= addrCur;
        rxReady    <= 1'b1;
        errParity  <= (errParity && !rdStrobe) | parBad;
        errFrame   <= (errFrame && !rdStrobe) | strb.frameErr;
        errOverrun <= (errOverrun && !rdStrobe) | (rxReady && !rdStrobe);
      end else if (rdStrobe) begin
        rxReady    <= 1'b0;
        errParity  <= 1'b0;
        errFrame   <= 1'b0;
        errOverrun <= 1'b0;
      end
      if (strb.setBreak) errBreak <= 1'b1;
      else if (rdStrobe) errBreak <= 1'b0;
    end
  end

  // R5: overrun only appears on top of an unread character
  assert_overrun_src_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errOverrun) |-> $past(rxReady));

  // R6: break only while the synchronized line is low
  assert_break_low_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errBreak) |-> !$past(lineS));

  // R7: a lone read empties the buffer and the error flags
  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && !strb.load && !strb.setBreak) |=> (!rxReady && !errAny));

  // R9: a filtered character never raises ready
  assert_sleep_drop_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && sleepEn && mpActive && !addrCur && !rxReady) |=> !rxReady);
endmodule

// File: rtl/async_rx.sv
module async_rx
  import async_rx_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int DATA_W = 8,
  parameter int LEN_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxEn,
  input  logic              rxLine,
  input  logic [DIV_W-1:0]  baudDiv,
  input  logic [LEN_W-1:0]  dataLen,
  input  logic              parityEn,
  input  logic              parityOdd,
  input  logic              twoStop,
  input  logic [1:0]        mpMode,
  input  logic              sleepEn,
  input  logic              rxIntEn,
  input  logic              rdStrobe,
  output logic [DATA_W-1:0] rxData,
  output logic              rxAddr,
  output logic              rxReady,
  output logic              errParity,
  output logic              errFrame,
  output logic              errOverrun,
  output logic              errBreak,
  output logic              errAny,
  output logic              rxIrq
);
  rxStrb_t strb;
  logic    tick, lineS;

  async_rx_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .rxEn(rxEn), .tick(tick), .lineS(lineS),
    .dataLen(dataLen), .parityEn(parityEn), .twoStop(twoStop),
    .mpMode(mpMode), .strb(strb)
  );

  async_rx_dp #(.DIV_W(DIV_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_dp (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .baudDiv(baudDiv),
    .dataLen(dataLen), .parityOdd(parityOdd), .mpMode(mpMode),
    .sleepEn(sleepEn), .rdStrobe(rdStrobe), .rxIntEn(rxIntEn), .strb(strb),
    .tick(tick), .lineS(lineS), .rxData(rxData), .rxAddr(rxAddr),
    .rxReady(rxReady), .errParity(errParity), .errFrame(errFrame),
    .errOverrun(errOverrun), .errBreak(errBreak), .errAny(errAny),
    .rxIrq(rxIrq)
  );
endmodule

// File: tb/async_rx_bench.sv
`timescale 1ns/1ps
module async_rx_bench;
  localparam int BDIV     = 1;
  localparam int BIT_CLKS = 8 * (BDIV + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxEn = 1'b1, rxLine = 1'b1;
  logic [15:0] baudDiv = 16'(BDIV);
  logic [2:0] dataLen = 3'd7;
  logic parityEn = 1'b0, parityOdd = 1'b0, twoStop = 1'b0;
  logic [1:0] mpMode = 2'd0;
  logic sleepEn = 1'b0, rxIntEn = 1'b0, rdStrobe = 1'b0;
  logic [7:0] rxData;
  logic rxAddr, rxReady, errParity, errFrame, errOverrun, errBreak, errAny, rxIrq;
  int nChecks = 0, nErr = 0;

  always #2 clk = ~clk;

  async_rx u_async_rx (
    .clk(clk), .rstN(rstN), .rxEn(rxEn), .rxLine(rxLine), .baudDiv(baudDiv),
    .dataLen(dataLen), .parityEn(parityEn), .parityOdd(parityOdd),
    .twoStop(twoStop), .mpMode(mpMode), .sleepEn(sleepEn), .rxIntEn(rxIntEn),
    .rdStrobe(rdStrobe), .rxData(rxData), .rxAddr(rxAddr), .rxReady(rxReady),
    .errParity(errParity), .errFrame(errFrame), .errOverrun(errOverrun),
    .errBreak(errBreak), .errAny(errAny), .rxIrq(rxIrq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] expData(input logic [7:0] d, input int len);
    logic [8:0] m;
    m = (9'd1 << len) - 9'd1;
    return d & m[7:0];
  endfunction

  function automatic logic parBit(input logic [7:0] d, input int len, input logic a);
    logic p;
    p = parityOdd ^ ((mpMode == 2'd2) ? a : 1'b0);
    for (int i = 0; i < len; i++) p ^= d[i];
    return p;
  endfunction

  task automatic sendBit(input logic v);
    rxLine = v;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  task automatic gap(input int n);
    for (int i = 0; i < n; i++) sendBit(1'b1);
  endtask

  task automatic sendChar(input logic [7:0] d, input int len, input logic a,
                          input logic flip, input logic stop1, input logic stop2);
    dataLen = 3'(len - 1);
    sendBit(1'b0);
    for (int i = 0; i < len; i++) sendBit(d[i]);
    if (mpMode == 2'd2) sendBit(a);
    if (parityEn) sendBit(parBit(d, len, a) ^ flip);
    sendBit(stop1);
    if (twoStop) sendBit(stop2);
  endtask

  // one-clock glitch of the opposite level in the middle of data bit idx
  task automatic glitchChar(input logic [7:0] d, input int idx);
    dataLen = 3'd7;
    sendBit(1'b0);
    for (int i = 0; i < 8; i++) begin
      if (i == idx) begin
        rxLine = d[i];
        repeat (BIT_CLKS / 2) @(negedge clk);
        rxLine = ~d[i];
        @(negedge clk);
        rxLine = d[i];
        repeat (BIT_CLKS / 2 - 1) @(negedge clk);
      end else begin
        sendBit(d[i]);
      end
    end
    sendBit(1'b1);
  endtask

  task automatic readBuf();
    rdStrobe = 1'b1;
    @(negedge clk);
    rdStrobe = 1'b0;
    @(negedge clk);
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nErr++;
    $display("FAIL R1 watchdog act=timeout exp=done");
    finishRun();
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd24680);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R7 reset ready", rxReady, 0);
    chk("R7 reset errAny", errAny, 0);
    chk("R8 reset irq", rxIrq, 0);
    gap(2);

    // R2: basic lengths
    sendChar(8'hA5, 8, 0, 0, 1, 1);
    chk("R2 len8 data", rxData, 8'hA5);
    chk("R2 len8 ready", rxReady, 1);
    chk("R8 irq gated off", rxIrq, 0);
    rxIntEn = 1'b1;
    @(negedge clk);
    chk("R8 irq on ready", rxIrq, 1);
    rxIntEn = 1'b0;
    readBuf();
    chk("R7 read clears ready", rxReady, 0);
    sendChar(8'hFF, 5, 0, 0, 1, 1);
    chk("R2 len5 data", rxData, 8'h1F);
    readBuf();
    sendChar(8'h01, 1, 0, 0, 1, 1);
    chk("R2 len1 data", rxData, 8'h01);
    readBuf();

    // R1: short start pulse rejected
    rxLine = 1'b0;
    repeat (4) @(negedge clk);
    gap(3);
    chk("R1 short start ignored", rxReady, 0);

    // R12: glitches inside data bits
    glitchChar(8'h00, 3);
    chk("R12 high glitch", rxData, 8'h00);
    readBuf();
    glitchChar(8'hFF, 5);
    chk("R12 low glitch", rxData, 8'hFF);
    readBuf();

    // R3: parity even and odd
    parityEn = 1'b1;
    sendChar(8'h3C, 8, 0, 0, 1, 1);
    chk("R3 even ok", errParity, 0);
    readBuf();
    sendChar(8'h3C, 8, 0, 1, 1, 1);
    chk("R3 even bad", errParity, 1);
    chk("R7 errAny parity", errAny, 1);
    readBuf();
    chk("R7 read clears errAny", errAny, 0);
    parityOdd = 1'b1;
    sendChar(8'h07, 6, 0, 1, 1, 1);
    chk("R3 odd bad", errParity, 1);
    readBuf();
    parityEn = 1'b0;
    parityOdd = 1'b0;

    // R5: overrun
    sendChar(8'h11, 8, 0, 0, 1, 1);
    sendChar(8'h22, 8, 0, 0, 1, 1);
    chk("R5 overrun flag", errOverrun, 1);
    chk("R5 data replaced", rxData, 8'h22);
    readBuf();
    chk("R7 overrun cleared", errOverrun, 0);

    // R4: framing and two stop bits
    twoStop = 1'b1;
    sendChar(8'h5A, 8, 0, 0, 1, 0);
    rxLine = 1'b1;
    gap(2);
    chk("R4 second stop unchecked", errFrame, 0);
    chk("R4 two-stop data", rxData, 8'h5A);
    readBuf();
    sendChar(8'h5A, 8, 0, 0, 0, 1);
    gap(1);
    chk("R4 first stop low", errFrame, 1);
    readBuf();
    twoStop = 1'b0;
    sendChar(8'h55, 8, 0, 0, 0, 1);
    rxLine = 1'b1;
    gap(2);
    chk("R4 framing error", errFrame, 1);
    chk("R6 short low no break", errBreak, 0);
    readBuf();

    // R6: break with interrupt gate closed
    sendChar(8'h00, 8, 0, 0, 0, 0);
    rxLine = 1'b0;
    repeat (11 * BIT_CLKS) @(negedge clk);
    gap(2);
    chk("R6 break flag", errBreak, 1);
    chk("R4 break frames", errFrame, 1);
    chk("R8 break irq ungated", rxIrq, 1);
    readBuf();
    chk("R7 break cleared", errBreak, 0);

    // R11: disabled receiver
    rxEn = 1'b0;
    sendChar(8'h99, 8, 0, 0, 1, 1);
    chk("R11 disabled no load", rxReady, 0);
    chk("R11 disabled no flags", errAny, 0);
    rxEn = 1'b1;
    gap(2);
    sendChar(8'h66, 8, 0, 0, 1, 1);
    chk("R11 re-enabled data", rxData, 8'h66);
    readBuf();

    // R9: address-bit mode with parity over the address bit
    mpMode = 2'd2;
    sleepEn = 1'b1;
    parityEn = 1'b1;
    sendChar(8'h47, 8, 0, 0, 1, 1);
    chk("R9 sleeping drops data char", rxReady, 0);
    sendChar(8'h81, 8, 1, 0, 1, 1);
    chk("R9 address char loaded", rxReady, 1);
    chk("R9 address flag", rxAddr, 1);
    chk("R3 parity covers address", errParity, 0);
    chk("R9 address data", rxData, 8'h81);
    readBuf();
    sleepEn = 1'b0;
    sendChar(8'h0F, 8, 0, 1, 1, 1);
    chk("R9 awake data char", rxAddr, 0);
    chk("R3 address mode bad parity", errParity, 1);
    readBuf();
    parityEn = 1'b0;

    // R10: idle-line mode
    mpMode = 2'd1;
    sleepEn = 1'b1;
    gap(12);
    sendChar(8'h3C, 8, 0, 0, 1, 1);
    chk("R10 after idle loaded", rxReady, 1);
    chk("R10 after idle is address", rxAddr, 1);
    readBuf();
    gap(1);
    sendChar(8'h12, 8, 0, 0, 1, 1);
    chk("R10 short gap dropped", rxReady, 0);
    gap(1);
    sleepEn = 1'b0;
    sendChar(8'h34, 8, 0, 0, 1, 1);
    chk("R10 short gap not address", rxAddr, 0);
    chk("R10 awake data", rxData, 8'h34);
    readBuf();
    mpMode = 2'd0;

    // random frames
    for (int k = 0; k < 30; k++) begin
      logic [7:0] d;
      int len;
      logic pf;
      d = 8'($urandom);
      len = 1 + int'($urandom % 8);
      parityEn = 1'($urandom);
      parityOdd = 1'($urandom);
      twoStop = 1'($urandom);
      pf = parityEn && (($urandom % 4) == 0);
      sendChar(d, len, 0, pf, 1, 1);
      chk("R2 random data", rxData, expData(d, len));
      chk("R3 random parity", errParity, pf);
      chk("R5 random no overrun", errOverrun, 0);
      readBuf();
      gap(int'($urandom % 3));
    end

    finishRun();
  end
endmodule